// File: doc/BRIEF.md
# Prioritised Memory Region Permission Checker

This block decides, one access at a time, whether an instruction fetch or a data access may proceed. It also decides whether a permitted load or store should use the data cache. Software fills two small tables of address regions, one for fetches and one for data. Each region holds an inclusive lower and upper address, a 3-bit permission code, a valid bit, and, on the data side only, a default cacheability bit. Regions may overlap. When several regions cover an address, the lowest-numbered one decides. A small region with no access rights, placed inside a larger one, therefore turns every access to that hole into a fault. This is the usual way to catch a stack growing into a heap.

A separate control write turns the checker on or off. It comes out of reset switched off. While it is off, every access is permitted. Two rules override any region setting and force an access to bypass the data cache: an explicitly uncached load or store, and an address whose most significant bit is set. The lookup port is registered. A request presented in one cycle is answered in the next, and back-to-back requests are answered at full rate.

Top module: `mpu_region_check`

## Requirements
- R1: After reset the checker is disabled, `rsp_valid` is 0, and `rsp_fault`, `rsp_hit`, `rsp_cacheable` and `rsp_index` are 0.
- R2: A valid region matches an address when base <= address <= limit, with both bounds inclusive. A region whose valid bit is 0 never matches.
- R3: When an address matches several regions of the table that is searched, the lowest-index match supplies the permission, the cacheability and `rsp_index`, and `rsp_hit` is 1.
- R4: An enabled lookup that hits a region with permission code 000 faults, even when a higher-index region covering the same address would allow the access.
- R5: While the checker is enabled, a lookup that matches no valid region gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_index`=0.
- R6: `lk_kind` 00 is a fetch and is checked only against the instruction table. 01 is a load and 1x is a store, and both are checked only against the data table.
- R7: Data permission codes grant the following, where S is supervisor (`lk_user`=0) and U is user:
  - 001: S read
  - 010: S read and write
  - 011: S read and write, U read
  - 100: S and U read and write
  - any other code: nothing

  Instruction permission codes grant the following:
  - 001: S fetch
  - 010: S and U fetch
  - any other code: nothing
- R8: `rsp_cacheable` is always 0 for fetches and for faulting accesses. For a permitted data access with the checker enabled, it follows the winning data region's cache bit, subject to R9 and R10.
- R9: A lookup with `lk_uncached`=1 always gives `rsp_cacheable`=0.
- R10: A lookup whose address has its most significant bit set (bit AW-1) always gives `rsp_cacheable`=0.
- R11: While disabled, every lookup gives `rsp_fault`=0, `rsp_hit`=0 and `rsp_index`=0. `rsp_cacheable` is 1 exactly for a load or store with `lk_uncached`=0 and address MSB 0. A `ctl_we` pulse loads `ctl_enable` as the new state.
- R12: `rsp_valid` equals `lk_valid` one cycle earlier. The response fields reflect the request and the tables as they stood in that earlier cycle. When `rsp_valid` is 0, all response fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Load the enable state |
| ctl_enable | input | 1 | New enable state |
| cfg_we | input | 1 | Write one region entry |
| cfg_data_side | input | 1 | 1 selects the data table, 0 the instruction table |
| cfg_idx | input | $clog2(NREG) | Entry index |
| cfg_base | input | AW | Inclusive lower address |
| cfg_limit | input | AW | Inclusive upper address |
| cfg_perm | input | 3 | Permission code |
| cfg_cache | input | 1 | Default cacheability (data table only) |
| cfg_valid | input | 1 | Entry in use |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | AW | Access address |
| lk_kind | input | 2 | 00 fetch, 01 load, 1x store |
| lk_user | input | 1 | 1 for user mode, 0 for supervisor |
| lk_uncached | input | 1 | Explicitly uncached load or store |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Access denied |
| rsp_cacheable | output | 1 | Access may use the data cache |
| rsp_hit | output | 1 | Some region matched |
| rsp_index | output | $clog2(NREG) | Winning region index |

## Verification
The bench builds the checker with NREG=4 and AW=8. At that size all 256 addresses can be swept for every access kind, privilege and uncached flag. Every region boundary, every overlap between regions, the no-match gaps and the address-MSB bypass are then hit exactly rather than by sampling. The bench runs several table programs in turn: one with a no-access hole inside a larger region, and one that moves to the remaining permission codes, including the unassigned ones. Both programs are checked with the checker enabled and disabled, against a model that the bench computes from its own copy of the written entries.

// File: rtl/mpu_pkg.sv
`timescale 1ns/1ps
package mpu_pkg;
    localparam logic [1:0] ACC_FETCH = 2'b00;
    localparam logic [1:0] ACC_LOAD  = 2'b01;

    // data-side permission decode
    function automatic logic data_grant(logic [2:0] code, logic is_wr, logic is_user);
        case (code)
            3'd1:    return !is_wr && !is_user;
            3'd2:    return !is_user;
            3'd3:    return !is_user || !is_wr;
            3'd4:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // instruction-side permission decode
    function automatic logic inst_grant(logic [2:0] code, logic is_user);
        case (code)
            3'd1:    return !is_user;
            3'd2:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mpu_region_table.sv
`timescale 1ns/1ps
module mpu_region_table #(
    parameter int NREG      = 8,
    parameter int AW        = 32,
    parameter bit HAS_CACHE = 1'b1,
    localparam int IW       = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [AW-1:0]     wr_base,
    input  logic [AW-1:0]     wr_limit,
    input  logic [2:0]        wr_perm,
    input  logic              wr_cache,
    input  logic              wr_valid,
    input  logic [AW-1:0]     look_addr,
    output logic [NREG-1:0]   hit_vec,
    output logic [NREG*3-1:0] perm_flat,
    output logic [NREG-1:0]   cache_vec
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] base;
        logic [AW-1:0] limit;
        logic [2:0]    perm;
        logic          cache;
    } entry_t;

    entry_t tbl_d [NREG];
    entry_t tbl_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            tbl_d[i] = tbl_q[i];
            if (wr_en && (int'(wr_idx) == i)) begin
                tbl_d[i].valid = wr_valid;
                tbl_d[i].base  = wr_base;
                tbl_d[i].limit = wr_limit;
                tbl_d[i].perm  = wr_perm;
                tbl_d[i].cache = HAS_CACHE ? wr_cache : 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n) tbl_q[i] <= '0;
            else        tbl_q[i] <= tbl_d[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit_vec[g]       = tbl_q[g].valid
                               && (look_addr >= tbl_q[g].base)
                               && (look_addr <= tbl_q[g].limit);
        assign perm_flat[g*3 +: 3] = tbl_q[g].perm;
        assign cache_vec[g]     = tbl_q[g].cache;
    end
endmodule

// File: rtl/mpu_prio_pick.sv
`timescale 1ns/1ps
module mpu_prio_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end
endmodule

// File: rtl/mpu_region_check.sv
`timescale 1ns/1ps
module mpu_region_check #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ctl_enable,
    input  logic          cfg_we,
    input  logic          cfg_data_side,
    input  logic [IW-1:0] cfg_idx,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_limit,
    input  logic [2:0]    cfg_perm,
    input  logic          cfg_cache,
    input  logic          cfg_valid,
    input  logic          lk_valid,
    input  logic [AW-1:0] lk_addr,
    input  logic [1:0]    lk_kind,
    input  logic          lk_user,
    input  logic          lk_uncached,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic          rsp_cacheable,
    output logic          rsp_hit,
    output logic [IW-1:0] rsp_index
);
    import mpu_pkg::*;

    typedef struct packed {
        logic          en;
        logic          valid;
        logic          fault;
        logic          cacheable;
        logic          hit;
        logic [IW-1:0] index;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0]   i_hit, d_hit, i_cache_unused, d_cache;
    logic [NREG*3-1:0] i_perm, d_perm;
    logic              i_any, d_any;
    logic [IW-1:0]     i_idx, d_idx;
    logic              en_now;

    mpu_region_table #(.NREG(NREG), .AW(AW), .HAS_CACHE(1'b0)) u_itbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && !cfg_data_side), .wr_idx(cfg_idx),
        .wr_base(cfg_base), .wr_limit(cfg_limit), .wr_perm(cfg_perm),
        .wr_cache(cfg_cache), .wr_valid(cfg_valid), .look_addr(lk_addr),
        .hit_vec(i_hit), .perm_flat(i_perm), .cache_vec(i_cache_unused)
    );

    mpu_region_table #(.NREG(NREG), .AW(AW), .HAS_CACHE(1'b1)) u_dtbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_data_side), .wr_idx(cfg_idx),
        .wr_base(cfg_base), .wr_limit(cfg_limit), .wr_perm(cfg_perm),
        .wr_cache(cfg_cache), .wr_valid(cfg_valid), .look_addr(lk_addr),
        .hit_vec(d_hit), .perm_flat(d_perm), .cache_vec(d_cache)
    );

    mpu_prio_pick #(.N(NREG)) u_ipick (.req(i_hit), .any(i_any), .idx(i_idx));
    mpu_prio_pick #(.N(NREG)) u_dpick (.req(d_hit), .any(d_any), .idx(d_idx));

    always_comb begin
        logic          is_fetch;
        logic          sel_any;
        logic [IW-1:0] sel_idx;
        logic [2:0]    sel_perm;
        logic          grant;
        logic          cache_src;

        is_fetch  = (lk_kind == ACC_FETCH);
        sel_any   = is_fetch ? i_any : d_any;
        sel_idx   = is_fetch ? i_idx : d_idx;
        sel_perm  = is_fetch ? i_perm[int'(i_idx)*3 +: 3] : d_perm[int'(d_idx)*3 +: 3];
        grant     = is_fetch ? inst_grant(sel_perm, lk_user)
                             : data_grant(sel_perm, lk_kind[1], lk_user);
        cache_src = 1'b1;

        st_d           = st_q;
        st_d.en        = ctl_we ? ctl_enable : st_q.en;
        st_d.valid     = lk_valid;
        st_d.fault     = 1'b0;
        st_d.cacheable = 1'b0;
        st_d.hit       = 1'b0;
        st_d.index     = '0;

        if (lk_valid) begin
            if (st_q.en) begin
                st_d.hit   = sel_any;
                st_d.index = sel_any ? sel_idx : '0;
                st_d.fault = !(sel_any && grant);
                cache_src  = d_cache[d_idx];
            end
            st_d.cacheable = !is_fetch && !st_d.fault && cache_src
                          && !lk_addr[AW-1] && !lk_uncached;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_now        = st_q.en;
    assign rsp_valid     = st_q.valid;
    assign rsp_fault     = st_q.fault;
    assign rsp_cacheable = st_q.cacheable;
    assign rsp_hit       = st_q.hit;
    assign rsp_index     = st_q.index;
endmodule

// File: rtl/mpu_region_check_sva.sv
`timescale 1ns/1ps
module mpu_region_check_sva #(
    parameter int NREG = 8,
    parameter int AW   = 32,
    localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_now,
    input logic          lk_valid,
    input logic [AW-1:0] lk_addr,
    input logic [1:0]    lk_kind,
    input logic          lk_uncached,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic          rsp_cacheable,
    input logic          rsp_hit,
    input logic [IW-1:0] rsp_index
);
    p_req_answered_r12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && !rsp_hit && !rsp_cacheable && rsp_index == '0));
    p_fault_uncached_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !rsp_cacheable);
    p_fetch_uncached_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'b00) |=> !rsp_cacheable);
    p_op_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_uncached) |=> !rsp_cacheable);
    p_msb_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_addr[AW-1]) |=> !rsp_cacheable);
    p_off_permits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !en_now) |=> (!rsp_fault && !rsp_hit));
    p_miss_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && en_now) |=> (rsp_hit || rsp_fault));
    p_miss_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_index == '0));
endmodule

bind mpu_region_check mpu_region_check_sva #(.NREG(NREG), .AW(AW)) u_sva (
    .clk(clk), .rst_n(rst_n), .en_now(en_now),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(lk_kind),
    .lk_uncached(lk_uncached), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cacheable(rsp_cacheable), .rsp_hit(rsp_hit), .rsp_index(rsp_index)
);

// File: tb/mpu_region_check_bench.sv
`timescale 1ns/1ps
module mpu_region_check_bench;
    localparam int NREG = 4;
    localparam int AW   = 8;
    localparam int IW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0, ctl_enable = 1'b0;
    logic          cfg_we = 1'b0, cfg_data_side = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_base = '0, cfg_limit = '0;
    logic [2:0]    cfg_perm = '0;
    logic          cfg_cache = 1'b0, cfg_valid = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic [1:0]    lk_kind = '0;
    logic          lk_user = 1'b0, lk_uncached = 1'b0;
    logic          rsp_valid, rsp_fault, rsp_cacheable, rsp_hit;
    logic [IW-1:0] rsp_index;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench copy of what was written
    int  m_en;
    int  mb [2][NREG];
    int  ml [2][NREG];
    int  mp [2][NREG];
    int  mc [2][NREG];
    int  mv [2][NREG];

    always #5 clk = ~clk;

    mpu_region_check #(.NREG(NREG), .AW(AW)) u_mpu_region_check (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_enable(ctl_enable),
        .cfg_we(cfg_we), .cfg_data_side(cfg_data_side), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_perm(cfg_perm),
        .cfg_cache(cfg_cache), .cfg_valid(cfg_valid), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_user(lk_user),
        .lk_uncached(lk_uncached), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cacheable(rsp_cacheable), .rsp_hit(rsp_hit), .rsp_index(rsp_index)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_region(int side, int idx, int b, int l, int p, int c, int v);
        cfg_we = 1'b1; cfg_data_side = side[0]; cfg_idx = idx[IW-1:0];
        cfg_base = b[AW-1:0]; cfg_limit = l[AW-1:0]; cfg_perm = p[2:0];
        cfg_cache = c[0]; cfg_valid = v[0];
        @(negedge clk);
        cfg_we = 1'b0;
        mb[side][idx] = b; ml[side][idx] = l; mp[side][idx] = p;
        mc[side][idx] = c; mv[side][idx] = v;
    endtask

    task automatic set_enable(int e);
        ctl_we = 1'b1; ctl_enable = e[0];
        @(negedge clk);
        ctl_we = 1'b0;
        m_en = e;
    endtask

    // expected response packed as {fault, cacheable, hit, index[1:0]}
    function automatic int model(int a, int k, int u, int un);
        int side, win, p, ok, f, c, h, x, wr;
        side = (k == 0) ? 0 : 1;
        wr = (k >= 2) ? 1 : 0;
        win = -1;
        for (int i = NREG - 1; i >= 0; i--)
            if (mv[side][i] != 0 && a >= mb[side][i] && a <= ml[side][i]) win = i;
        f = 0; h = 0; x = 0; c = 1;
        if (m_en != 0) begin
            if (win < 0) begin
                f = 1;
            end else begin
                h = 1; x = win; p = mp[side][win];
                if (side == 0) ok = (u == 0) ? (p == 1 || p == 2) : (p == 2);
                else if (u == 0) ok = wr ? (p >= 2 && p <= 4) : (p >= 1 && p <= 4);
                else ok = wr ? (p == 4) : (p == 3 || p == 4);
                f = ok ? 0 : 1;
                c = (side == 1) ? mc[1][win] : 0;
            end
        end
        if (side == 0 || f != 0 || un != 0 || a >= 128) c = 0;
        return (f << 4) | (c << 3) | (h << 2) | x;
    endfunction

    // full sweep, back-to-back requests, each checked one cycle later
    task automatic sweep(string req);
        int exp_q, have;
        have = 0; exp_q = 0;
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 3; k++)
                for (int u = 0; u < 2; u++)
                    for (int un = 0; un < 2; un++) begin
                        lk_valid = 1'b1; lk_addr = a[AW-1:0];
                        lk_kind = (k == 2) ? 2'b10 : k[1:0];
                        lk_user = u[0]; lk_uncached = un[0];
                        @(negedge clk);
                        check({req, " R12 valid"}, int'(rsp_valid), 1);
                        check(req, {27'd0, rsp_fault, rsp_cacheable, rsp_hit, rsp_index},
                              model(a, k, u, un));
                    end
        lk_valid = 1'b0;
        @(negedge clk);
        check("R12 idle response", {26'd0, rsp_valid, rsp_fault, rsp_cacheable,
              rsp_hit, rsp_index}, 0);
    endtask

    initial begin
        m_en = 0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < NREG; i++) begin
                mb[s][i] = 0; ml[s][i] = 0; mp[s][i] = 0; mc[s][i] = 0; mv[s][i] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset response", {26'd0, rsp_valid, rsp_fault, rsp_cacheable,
              rsp_hit, rsp_index}, 0);

        // empty tables, disabled: all permitted
        sweep("R1 R11 R9 R10 disabled empty");

        // program A: hole inside larger region, overlaps, gaps
        write_region(0, 0, 8'h10, 8'h3F, 2, 0, 1);
        write_region(0, 1, 8'h00, 8'h7F, 1, 0, 1);
        write_region(0, 2, 8'h80, 8'hBF, 2, 0, 0);   // invalid entry
        write_region(0, 3, 8'hC0, 8'hFF, 1, 0, 1);
        write_region(1, 0, 8'h50, 8'h53, 0, 1, 1);   // no-access hole
        write_region(1, 1, 8'h40, 8'h9F, 4, 1, 1);
        write_region(1, 2, 8'h00, 8'h4F, 3, 0, 1);
        write_region(1, 3, 8'hA0, 8'hEF, 1, 1, 1);
        sweep("R11 disabled with tables");
        set_enable(1);
        sweep("R2 R3 R4 R5 R6 R7 R8 R9 R10 enabled A");

        // program B: remaining permission codes, unassigned codes
        write_region(0, 0, 8'h10, 8'h3F, 4, 1, 1);
        write_region(0, 2, 8'h80, 8'hBF, 3, 0, 1);
        write_region(1, 1, 8'h40, 8'h9F, 2, 0, 1);
        write_region(1, 2, 8'h00, 8'h4F, 7, 1, 1);
        write_region(1, 3, 8'hA0, 8'hEF, 5, 1, 1);
        write_region(1, 0, 8'h50, 8'h53, 3, 1, 0);   // hole retired
        sweep("R2 R3 R5 R6 R7 R8 enabled B");

        set_enable(0);
        sweep("R11 re-disabled");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule